// File: doc/BRIEF.md
# Vertex Attribute Fetch Sequencer

This block turns one vertex number into the stream of memory reads needed to gather that vertex's input attributes. A packed 64-bit descriptor gives, for each of twelve attribute slots, an element format and a component count. A default mask and the attribute total say which attributes exist and which are supplied from fallback storage elsewhere. Each attribute also has a source base address. After a start strobe, the sequencer walks the attributes and their components. For each memory component it issues one read and widens the returned element to 32 bits according to its format. It then emits a record tagged with attribute, component and format.

An attribute routed to fallback storage gets no memory read. It produces a single tagged record, so that the downstream stage knows to substitute its stored vector. Conversion of the raw values to floating point happens downstream. A one-cycle done pulse closes each vertex.

Top module: `vertex_attr_fetch`

## Requirements
- R1: Configuration writes go to address 0 (descriptor bits 31:0), address 1 (descriptor bits 63:32) or address 2+i (source base of attribute i, i from 0 to 11); other addresses have no effect. In the descriptor, attribute i keeps its format in bits 4i+1:4i and its component count minus one in bits 4i+3:4i+2. Bit 48+i is its default-mask bit, and bits 63:60 hold the number of attributes minus one.
- R2: Format code 0 is a signed byte and is sign-extended from bit 7. Code 1 is an unsigned byte and is zero-extended. Code 2 is a signed 16-bit value and is sign-extended from bit 15. Code 3 is a 32-bit float and is passed through unchanged. The record carries the format code.
- R3: Element size is 1 byte for codes 0 and 1, 2 bytes for code 2 and 4 bytes for code 3. Stride is the component count times the element size. The read address for component c is source + stride × vertex + c × element size, taken modulo 2^ADDR_W.
- R4: An attribute whose index is 12 or more, or whose mask bit is set, issues no read. It emits exactly one record with the default flag 1, component 0, value 0 and format 0.
- R5: Records come out for attributes 0 up to the attribute total minus one, in ascending attribute order, with components ascending within each attribute. A memory attribute yields exactly (count minus one)+1 records.
- R6: done is high for exactly one cycle, in the cycle right after the vertex's last record.
- R7: At most one read is outstanding. memReq is a one-cycle pulse, and the record for that read appears in the cycle after memRvalid is sampled high.
- R8: A start strobe while a vertex is in progress is ignored; the running vertex and its records are unchanged, and no extra vertex follows.
- R9: Configuration writes made while a vertex is in progress are discarded. Neither that vertex nor later ones see them.
- R10: Reset clears all configuration to zero and holds outValid, memReq and done low. After reset, one start produces a single record: attribute 0, signed byte, read from address equal to the vertex number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| start | input | 1 | Start strobe for one vertex |
| startVertex | input | VTX_W | Vertex number captured with start |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | ADDR_W | Byte address of the read |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data, element right-aligned |
| outValid | output | 1 | Record valid |
| outAttr | output | 4 | Attribute index of the record |
| outComp | output | 2 | Component index of the record |
| outValue | output | 32 | Widened raw element value |
| outFormat | output | 2 | Element format code of the record |
| outDefault | output | 1 | Attribute comes from fallback storage |
| done | output | 1 | One-cycle end-of-vertex pulse |

## Verification
Two control inputs can coincide with an in-flight fetch: a new start strobe and a configuration write. Both may arrive in a cycle where the sequencer is waiting on a read response. The bench drives a second start and writes to the active attribute's source base and to the descriptor in the middle of a long sixteen-attribute vertex. The scoreboard must then see the original address and record sequence drained with nothing extra. A following vertex must still be built from the configuration that was in place before the discarded writes.

// File: rtl/vaf_pkg.sv
package vaf_pkg;

  localparam int SLOT_CNT   = 12;              // attribute slots with memory descriptors
  localparam int ATTR_W     = 4;               // width of the attribute-total field
  localparam int IDX_CNT    = 1 << ATTR_W;     // addressable attribute indices
  localparam int COMP_W     = 2;
  localparam int WORD_W     = 32;
  localparam int DESC_W     = 2 * WORD_W;
  localparam int CFG_AW     = 4;
  localparam int SLOT_PITCH = 4;
  localparam int MASK_LSB   = 48;
  localparam int CNT_LSB    = 60;
  localparam int SRC_BASE   = 2;

  typedef enum logic [1:0] {
    FMT_S8  = 2'd0,
    FMT_U8  = 2'd1,
    FMT_S16 = 2'd2,
    FMT_F32 = 2'd3
  } elemFmt_t;

  // control -> datapath
  typedef struct packed {
    logic latchVertex;
    logic issueReq;
    logic captureRsp;
    logic emitDefault;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic isDefault;
    logic lastComp;
    logic lastAttr;
  } attrStatus_t;

  function automatic logic [2:0] elemBytes(input elemFmt_t fmt);
    case (fmt)
      FMT_F32: elemBytes = 3'd4;
      FMT_S16: elemBytes = 3'd2;
      default: elemBytes = 3'd1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] widenElem(input elemFmt_t fmt,
                                                  input logic [WORD_W-1:0] raw);
    case (fmt)
      FMT_S8:  widenElem = {{(WORD_W-8){raw[7]}}, raw[7:0]};
      FMT_U8:  widenElem = {{(WORD_W-8){1'b0}}, raw[7:0]};
      FMT_S16: widenElem = {{(WORD_W-16){raw[15]}}, raw[15:0]};
      default: widenElem = raw;
    endcase
  endfunction

endpackage

// File: rtl/vaf_ctrl.sv
module vaf_ctrl
  import vaf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                memRvalid,
  input  attrStatus_t         stat,
  output seqStrobe_t          stb,
  output logic [ATTR_W-1:0]   attrIdx,
  output logic [COMP_W-1:0]   compIdx,
  output logic                idle,
  output logic                done
);

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_FIN   = 2'd3
  } seqState_t;

  seqState_t state;

  assign idle = (state == S_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      S_IDLE:  stb.latchVertex = start;
      S_ISSUE: begin
        if (stat.isDefault) stb.emitDefault = 1'b1;
        else                stb.issueReq    = 1'b1;
      end
      S_WAIT:  stb.captureRsp = memRvalid;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      attrIdx <= '0;
      compIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_ISSUE;
            attrIdx <= '0;
            compIdx <= '0;
          end
        end
        S_ISSUE: begin
          if (stat.isDefault) begin
            if (stat.lastAttr) begin
              state <= S_FIN;
            end else begin
              attrIdx <= attrIdx + 1'b1;
              compIdx <= '0;
            end
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (memRvalid) begin
            if (stat.lastComp) begin
              if (stat.lastAttr) begin
                state <= S_FIN;
              end else begin
                state   <= S_ISSUE;
                attrIdx <= attrIdx + 1'b1;
                compIdx <= '0;
              end
            end else begin
              state   <= S_ISSUE;
              compIdx <= compIdx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // attribute index never moves backwards inside one vertex
  assert_attr_ascend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && $past(state) != S_IDLE) |-> (attrIdx >= $past(attrIdx)));

  // a busy sequencer never takes a fresh start
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && start && !memRvalid) |=> (state == S_WAIT));

endmodule

// File: rtl/vaf_datapath.sv
module vaf_datapath
  import vaf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VTX_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [WORD_W-1:0]   cfgData,
  input  logic                idle,
  input  logic [VTX_W-1:0]    startVertex,
  input  seqStrobe_t          stb,
  input  logic [ATTR_W-1:0]   attrIdx,
  input  logic [COMP_W-1:0]   compIdx,
  input  logic [WORD_W-1:0]   memRdata,
  output attrStatus_t         stat,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                outValid,
  output logic [ATTR_W-1:0]   outAttr,
  output logic [COMP_W-1:0]   outComp,
  output logic [WORD_W-1:0]   outValue,
  output logic [1:0]          outFormat,
  output logic                outDefault
);

  logic [DESC_W-1:0] descReg;
  logic [ADDR_W-1:0] srcReg [SLOT_CNT];
  logic [VTX_W-1:0]  vertexReg;
  logic              cfgOpen;

  assign cfgOpen = cfgWe & idle;

  // configuration storage, writable only between vertices
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descReg <= '0;
      for (int i = 0; i < SLOT_CNT; i++) srcReg[i] <= '0;
    end else if (cfgOpen) begin
      if (cfgAddr == CFG_AW'(0)) descReg[WORD_W-1:0]      <= cfgData;
      if (cfgAddr == CFG_AW'(1)) descReg[DESC_W-1:WORD_W] <= cfgData;
      for (int i = 0; i < SLOT_CNT; i++) begin
        if (cfgAddr == CFG_AW'(SRC_BASE + i)) srcReg[i] <= ADDR_W'(cfgData);
      end
    end
  end

  // per-index view of the descriptor; indices past the slot range are fixed defaults
  elemFmt_t          slotFmt  [IDX_CNT];
  logic [1:0]        slotSize [IDX_CNT];
  logic              slotDflt [IDX_CNT];
  logic [ADDR_W-1:0] slotSrc  [IDX_CNT];

  for (genvar gi = 0; gi < IDX_CNT; gi++) begin : g_slot
    if (gi < SLOT_CNT) begin : g_mem
      assign slotFmt[gi]  = elemFmt_t'(descReg[gi*SLOT_PITCH +: 2]);
      assign slotSize[gi] = descReg[gi*SLOT_PITCH+2 +: 2];
      assign slotDflt[gi] = descReg[MASK_LSB+gi];
      assign slotSrc[gi]  = srcReg[gi];
    end else begin : g_fix
      assign slotFmt[gi]  = FMT_S8;
      assign slotSize[gi] = 2'd0;
      assign slotDflt[gi] = 1'b1;
      assign slotSrc[gi]  = '0;
    end
  end

  elemFmt_t          curFmt;
  logic [1:0]        curSize;
  logic [ADDR_W-1:0] curSrc;
  logic [2:0]        esize;
  logic [2:0]        compCnt;
  logic [5:0]        strideBytes;
  logic [ADDR_W-1:0] reqAddr;

  assign curFmt  = slotFmt[attrIdx];
  assign curSize = slotSize[attrIdx];
  assign curSrc  = slotSrc[attrIdx];

  assign stat.isDefault = slotDflt[attrIdx];
  assign stat.lastComp  = (compIdx == curSize);
  assign stat.lastAttr  = (attrIdx == descReg[CNT_LSB +: ATTR_W]);

  assign esize       = elemBytes(curFmt);
  assign compCnt     = {1'b0, curSize} + 3'd1;
  assign strideBytes = {3'b000, compCnt} * {3'b000, esize};
  assign reqAddr     = curSrc
                     + ADDR_W'(strideBytes) * ADDR_W'(vertexReg)
                     + ADDR_W'(compIdx) * ADDR_W'(esize);

  always_ff @(posedge clk) begin
    if (!rstN) vertexReg <= '0;
    else if (stb.latchVertex) vertexReg <= startVertex;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq  <= 1'b0;
      memAddr <= '0;
    end else begin
      memReq <= stb.issueReq;
      if (stb.issueReq) memAddr <= reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outAttr    <= '0;
      outComp    <= '0;
      outValue   <= '0;
      outFormat  <= '0;
      outDefault <= 1'b0;
    end else begin
      outValid <= stb.captureRsp | stb.emitDefault;
      if (stb.captureRsp) begin
        outAttr    <= attrIdx;
        outComp    <= compIdx;
        outValue   <= widenElem(curFmt, memRdata);
        outFormat  <= curFmt;
        outDefault <= 1'b0;
      end else if (stb.emitDefault) begin
        outAttr    <= attrIdx;
        outComp    <= '0;
        outValue   <= '0;
        outFormat  <= FMT_S8;
        outDefault <= 1'b1;
      end
    end
  end

  assert_sext_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDefault && outFormat == FMT_S8) |->
      (outValue[WORD_W-1:7] == '0 || outValue[WORD_W-1:7] == '1));

  assert_zext_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDefault && outFormat == FMT_U8) |-> (outValue[WORD_W-1:8] == '0));

  assert_sext_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDefault && outFormat == FMT_S16) |->
      (outValue[WORD_W-1:15] == '0 || outValue[WORD_W-1:15] == '1));

  assert_default_record_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDefault) |-> (outValue == '0 && outComp == '0));

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> $stable(descReg));

endmodule

// File: rtl/vertex_attr_fetch.sv
module vertex_attr_fetch
  import vaf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VTX_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [WORD_W-1:0]    cfgData,
  input  logic                 start,
  input  logic [VTX_W-1:0]     startVertex,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memRvalid,
  input  logic [WORD_W-1:0]    memRdata,
  output logic                 outValid,
  output logic [ATTR_W-1:0]    outAttr,
  output logic [COMP_W-1:0]    outComp,
  output logic [WORD_W-1:0]    outValue,
  output logic [1:0]           outFormat,
  output logic                 outDefault,
  output logic                 done
);

  seqStrobe_t          stb;
  attrStatus_t         stat;
  logic [ATTR_W-1:0]   attrIdx;
  logic [COMP_W-1:0]   compIdx;
  logic                idle;

  vaf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memRvalid (memRvalid),
    .stat      (stat),
    .stb       (stb),
    .attrIdx   (attrIdx),
    .compIdx   (compIdx),
    .idle      (idle),
    .done      (done)
  );

  vaf_datapath #(
    .ADDR_W (ADDR_W),
    .VTX_W  (VTX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgAddr     (cfgAddr),
    .cfgData     (cfgData),
    .idle        (idle),
    .startVertex (startVertex),
    .stb         (stb),
    .attrIdx     (attrIdx),
    .compIdx     (compIdx),
    .memRdata    (memRdata),
    .stat        (stat),
    .memReq      (memReq),
    .memAddr     (memAddr),
    .outValid    (outValid),
    .outAttr     (outAttr),
    .outComp     (outComp),
    .outValue    (outValue),
    .outFormat   (outFormat),
    .outDefault  (outDefault)
  );

  assert_done_after_record_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outValid));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_single_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (!outValid && !memReq && !done));

endmodule

// File: tb/sim_vertex_attr_fetch.sv
module sim_vertex_attr_fetch;

  localparam int AW = 32;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWe;
  logic [3:0]    cfgAddr;
  logic [31:0]   cfgData;
  logic          start;
  logic [VW-1:0] stVtx;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic          memRvalid;
  logic [31:0]   memRdata;
  logic          outValid;
  logic [3:0]    outAttr;
  logic [1:0]    outComp;
  logic [31:0]   outValue;
  logic [1:0]    outFormat;
  logic          outDefault;
  logic          done;

  always #5 clk = ~clk;

  vertex_attr_fetch #(.ADDR_W(AW), .VTX_W(VW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .start(start), .startVertex(stVtx), .memReq(memReq), .memAddr(memAddr),
    .memRvalid(memRvalid), .memRdata(memRdata), .outValid(outValid),
    .outAttr(outAttr), .outComp(outComp), .outValue(outValue),
    .outFormat(outFormat), .outDefault(outDefault), .done(done)
  );

  typedef struct packed {
    logic [3:0]  attr;
    logic [1:0]  comp;
    logic [31:0] value;
    logic [1:0]  fmt;
    logic        dflt;
  } rec_t;

  rec_t        recQ[$];
  logic [31:0] addrQ[$];
  int          checks = 0;
  int          bad = 0;
  int          cyc = 0;
  int          rvCycle = 0;
  int          lastOutCycle = 0;
  string       phase = "R10";
  logic [63:0] mDesc = '0;
  logic [31:0] mSrc [12];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  // R2 widening as stated in the requirement
  function automatic logic [31:0] widen(input logic [1:0] f, input logic [31:0] w);
    if (f == 2'd0)      return {{24{w[7]}}, w[7:0]};
    else if (f == 2'd1) return {24'h0, w[7:0]};
    else if (f == 2'd2) return {{16{w[15]}}, w[15:0]};
    else                return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d, input bit lands);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (lands) begin
      if (a == 4'd0)      mDesc[31:0]  = d;
      else if (a == 4'd1) mDesc[63:32] = d;
      else if (a >= 4'd2 && a <= 4'd13) mSrc[a - 4'd2] = d;
    end
  endtask

  // driver side of the scoreboard: R1 R3 R4 R5 expectations
  task automatic expectVertex(input logic [15:0] v);
    for (int a = 0; a <= int'(mDesc[63:60]); a++) begin
      rec_t r;
      if (a >= 12 || mDesc[48 + a]) begin
        r.attr = 4'(a); r.comp = 2'd0; r.value = 32'h0; r.fmt = 2'd0; r.dflt = 1'b1;
        recQ.push_back(r);
      end else begin
        logic [1:0] f;
        int n;
        int es;
        f  = mDesc[4*a +: 2];
        n  = int'(mDesc[4*a+2 +: 2]) + 1;
        es = (f == 2'd3) ? 4 : (f == 2'd2) ? 2 : 1;
        for (int c = 0; c < n; c++) begin
          logic [31:0] ad;
          ad = mSrc[a] + 32'(n * es) * 32'(v) + 32'(c * es);
          addrQ.push_back(ad);
          r.attr = 4'(a); r.comp = 2'(c); r.value = widen(f, memWord(ad));
          r.fmt = f; r.dflt = 1'b0;
          recQ.push_back(r);
        end
      end
    end
  endtask

  task automatic kick(input logic [15:0] v);
    @(negedge clk);
    start = 1'b1; stVtx = v;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R6", "done seen", 64'(done), 64'd1);
    chk(cyc == lastOutCycle + 1, "R6", "done one cycle after last record",
        64'(cyc), 64'(lastOutCycle + 1));
    @(negedge clk);
    chk(!done, "R6", "done lasts one cycle", 64'(done), 64'd0);
    chk(recQ.size() == 0, "R5", "all records produced", 64'(recQ.size()), 64'd0);
    chk(addrQ.size() == 0, "R3", "all reads issued", 64'(addrQ.size()), 64'd0);
  endtask

  task automatic runVertex(input logic [15:0] v);
    expectVertex(v);
    kick(v);
    waitDone();
  endtask

  // memory model: checks addresses (R3), answers with rotating latency (R7)
  initial begin
    logic [31:0] a;
    int lat;
    lat = 0;
    memRvalid = 1'b0;
    memRdata  = 32'h0;
    forever begin
      @(negedge clk);
      if (memReq === 1'b1) begin
        a = memAddr;
        if (addrQ.size() == 0) chk(1'b0, "R3", "unexpected read", 64'(a), 64'd0);
        else begin
          logic [31:0] e;
          e = addrQ.pop_front();
          chk(a == e, "R3", "read address", 64'(a), 64'(e));
        end
        repeat (lat) @(negedge clk);
        memRvalid = 1'b1;
        memRdata  = memWord(a);
        rvCycle   = cyc;
        @(negedge clk);
        memRvalid = 1'b0;
        memRdata  = 32'hDEAD_BEEF;
        lat = (lat + 1) % 4;
      end
    end
  end

  // monitor: pops expected records and compares
  initial begin
    rec_t got;
    rec_t exp;
    forever begin
      @(negedge clk);
      if (outValid === 1'b1) begin
        got.attr = outAttr; got.comp = outComp; got.value = outValue;
        got.fmt = outFormat; got.dflt = outDefault;
        lastOutCycle = cyc;
        if (recQ.size() == 0) chk(1'b0, "R5", "unexpected record", 64'(got), 64'd0);
        else begin
          exp = recQ.pop_front();
          chk(got == exp, phase, $sformatf("record a%0d c%0d", exp.attr, exp.comp),
              64'(got), 64'(exp));
          if (!exp.dflt)
            chk(cyc == rvCycle + 1, "R7", "record one cycle after response",
                64'(cyc), 64'(rvCycle + 1));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) mSrc[i] = 32'h0;
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; start = 1'b0; stVtx = '0;
    repeat (3) @(negedge clk);
    chk(!outValid && !memReq && !done, "R10", "quiet in reset",
        {61'h0, outValid, memReq, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !memReq && !done, "R10", "quiet after reset",
        {61'h0, outValid, memReq, done}, 64'd0);

    // R10: zeroed configuration gives one signed byte read at the vertex number
    phase = "R10";
    runVertex(16'd5);

    // R1 R2 R3: float x4, byte x3, ubyte x2, short x4, masked attr 4, byte x1
    phase = "R1";
    cfgWrite(4'd0, 32'h0003_E58F, 1'b1);
    cfgWrite(4'd1, 32'h5010_0000, 1'b1);
    for (int i = 0; i < 12; i++)
      cfgWrite(4'(2 + i), 32'h4000_0000 + 32'(i) * 32'h0010_0400 + 32'(i * 3), 1'b1);
    cfgWrite(4'd15, 32'hFFFF_FFFF, 1'b0);   // R1: unmapped address has no effect
    runVertex(16'd0);
    phase = "R2";
    runVertex(16'd3);
    phase = "R3";
    runVertex(16'hFFFF);

    // R4: sixteen attributes, mask on 2 and 9, 12..15 by index
    phase = "R4";
    cfgWrite(4'd0, 32'h9C6B_2E47, 1'b1);
    cfgWrite(4'd1, 32'hF204_7A1D, 1'b1);
    runVertex(16'd7);
    runVertex(16'h1234);

    // R8 R9: stray start and config writes during an in-flight fetch
    phase = "R8";
    expectVertex(16'd9);
    kick(16'd9);
    repeat (3) @(negedge clk);
    start = 1'b1; stVtx = 16'd77;
    @(negedge clk);
    start = 1'b0;
    cfgWrite(4'd2, 32'h7777_0000, 1'b0);
    cfgWrite(4'd1, 32'h0000_0000, 1'b0);
    waitDone();
    repeat (10) @(negedge clk);
    chk(recQ.size() == 0 && addrQ.size() == 0, "R8", "no extra vertex after stray start",
        64'(recQ.size() + addrQ.size()), 64'd0);
    phase = "R9";
    runVertex(16'd2);

    // R5: two attributes, ubyte x2 then short x4
    phase = "R5";
    cfgWrite(4'd0, 32'h0000_00E5, 1'b1);
    cfgWrite(4'd1, 32'h1000_0000, 1'b1);
    runVertex(16'd100);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule